// File: doc/BRIEF.md
# Image Header Skip and Payload Truncate Filter

This block is a byte-stream filter placed between a configuration image source and the port that programs a device. Each image carries a leading header region that the device must not see. The filter takes that header as its byte count and discards it. It forwards the payload that follows. The payload can be cut to a programmed length, and any bytes after that point are thrown away. Both the upstream and the downstream side use a valid/ready handshake with a last flag.

A start pulse, taken only while the filter is idle, captures three 32-bit lengths: the header length, the payload length and the whole image length. A payload length of zero means the payload runs to the end of the image. The header and payload regions must fit inside the image. If they do not, the filter flags an error, forwards nothing and still drains the image. The filter reports completion once the upstream last byte has been consumed.

Top module: `img_window_filter`

## Requirements
- R1: After reset the filter is idle: `in_ready_o`, `out_valid_o`, `out_last_o`, `busy_o`, `done_o` and `err_o` are all 0, and no input byte is accepted while idle.
- R2: Input bytes at image offsets below the header length are accepted with `in_ready_o`=1 whatever `out_ready_i` is, and they are never presented at the output.
- R3: A header length of zero is legal; the first image byte (offset 0) is then forwarded.
- R4: The payload starts at the offset equal to the header length, counted from the first image byte after start. Payload bytes are forwarded unchanged and in order with zero latency. While a payload byte waits on `out_ready_i`=0, `in_ready_o` is 0.
- R5: With a payload length of zero, every byte from the header length up to the image length (or up to the input last byte, whichever comes first) is forwarded.
- R6: Once the programmed payload length has been forwarded, any further input bytes are accepted with `in_ready_o`=1 and discarded.
- R7: `out_last_o` is 1 on the final forwarded byte. That byte is either the one at offset header+payload-1 (image length-1 when the payload length is zero) or the payload byte carrying `in_last_i`.
- R8: If header length + payload length > image length, `err_o` goes to 1 from the cycle after start and stays there until the next accepted start. No byte is forwarded, and the input is still drained.
- R9: `busy_o` is 1 from the cycle after an accepted start. The cycle after the byte with `in_last_i` is consumed, `busy_o` is 0 and `done_o` pulses 1 for exactly one cycle.
- R10: A start pulse while `busy_o`=1 is ignored; the transfer in progress keeps its captured lengths.
- R11: Length arithmetic is 32 bits wide with no wrap: the fit sum is formed one bit wider, so a header near 2^32 plus a payload that would wrap is still reported as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that captures the three lengths when idle |
| hdr_len_i | input | 32 | Header byte count to skip |
| pay_len_i | input | 32 | Payload byte count; 0 runs to image end |
| img_len_i | input | 32 | Total image byte count |
| in_valid_i | input | 1 | Upstream byte valid |
| in_data_i | input | 8 | Upstream byte |
| in_last_i | input | 1 | Upstream final byte of the image |
| in_ready_o | output | 1 | Filter accepts the upstream byte |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_data_o | output | 8 | Forwarded byte |
| out_last_o | output | 1 | Final forwarded payload byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the last input byte |
| err_o | output | 1 | Regions do not fit in the image |

## Verification
The forwarding path is combinational, so `out_valid_o`, `out_data_o`, `out_last_o` and `in_ready_o` answer a byte in the same cycle it is driven. The bench drives on the falling edge and samples these one nanosecond later, before the rising edge that completes the handshake. `busy_o` and `err_o` are due one cycle after the start pulse. `done_o` is due one cycle after the last byte's handshake, and falls again one cycle later. The bench samples each of them just after the falling edge of exactly that cycle. Expected streams come from a separate window calculation done in 64-bit integers in the bench.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned WF_LEN_W = 32;

  typedef logic [WF_LEN_W-1:0] wf_len_t;

  typedef enum logic [1:0] {
    WF_IDLE  = 2'd0,
    WF_PASS  = 2'd1,
    WF_DRAIN = 2'd2
  } wf_state_e;

  // Header and payload must fit inside the image; sum one bit wider so it cannot wrap.
  function automatic logic regions_fit(input wf_len_t hdr, input wf_len_t pay, input wf_len_t img);
    logic [WF_LEN_W:0] sum;
    sum = {1'b0, hdr} + {1'b0, pay};
    return sum <= {1'b0, img};
  endfunction

  // Exclusive end offset of the forwarded window.
  function automatic wf_len_t window_end(input wf_len_t hdr, input wf_len_t pay, input wf_len_t img);
    return (pay == '0) ? img : (hdr + pay);
  endfunction

  function automatic logic in_window(input wf_len_t pos, input wf_len_t lo, input wf_len_t hi);
    return (pos >= lo) && (pos < hi);
  endfunction
endpackage

// File: rtl/wf_len_check.sv
module wf_len_check
  import wf_pkg::*;
(
  input  wf_len_t hdr_i,
  input  wf_len_t pay_i,
  input  wf_len_t img_i,
  output logic    fit_o,
  output wf_len_t end_o
);
  always_comb begin
    fit_o = regions_fit(hdr_i, pay_i, img_i);
    end_o = window_end(hdr_i, pay_i, img_i);
  end

  // R11: a fitting request never yields a window end below its header start
  always_comb begin
    if (fit_o) begin
      p_end_no_wrap_r11: assert (end_o >= hdr_i && end_o <= img_i)
        else $error("window end wrapped");
    end
  end
endmodule

// File: rtl/wf_seq.sv
module wf_seq
  import wf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      fit_i,
  input  wf_len_t   hdr_i,
  input  wf_len_t   end_i,
  input  logic      beat_i,
  input  logic      last_i,
  output wf_state_e state_o,
  output wf_len_t   pos_o,
  output wf_len_t   hdr_q_o,
  output wf_len_t   end_q_o,
  output logic      busy_o,
  output logic      err_o,
  output logic      done_o
);
  wf_state_e state_q;
  wf_len_t   pos_q, hdr_q, end_q;
  logic      err_q, done_q;

  wire start_take = start_i && (state_q == WF_IDLE);
  wire last_take  = beat_i && last_i && (state_q != WF_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WF_IDLE;
      pos_q   <= '0;
      hdr_q   <= '0;
      end_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_take;
      if (start_take) begin
        state_q <= fit_i ? WF_PASS : WF_DRAIN;
        pos_q   <= '0;
        hdr_q   <= hdr_i;
        end_q   <= end_i;
        err_q   <= !fit_i;
      end else if (beat_i && state_q != WF_IDLE) begin
        if (pos_q != '1) pos_q <= pos_q + 1'b1;
        if (last_i) state_q <= WF_IDLE;
      end
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign hdr_q_o = hdr_q;
  assign end_q_o = end_q;
  assign busy_o  = (state_q != WF_IDLE);
  assign err_o   = err_q;
  assign done_o  = done_q;

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (done_o && !busy_o));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(hdr_q) && $stable(end_q)));

  p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && busy_o && !last_i && !start_i && pos_q != '1) |=> (pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/wf_steer.sv
module wf_steer
  import wf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wf_state_e         state_i,
  input  wf_len_t           pos_i,
  input  wf_len_t           hdr_q_i,
  input  wf_len_t           end_q_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              beat_o
);
  logic fwd_win, at_tail, busy;

  always_comb begin
    busy        = (state_i != WF_IDLE);
    fwd_win     = (state_i == WF_PASS) && in_window(pos_i, hdr_q_i, end_q_i);
    at_tail     = (pos_i == end_q_i - 1'b1);
    out_valid_o = in_valid_i && fwd_win;
    out_data_o  = in_data_i;
    out_last_o  = out_valid_o && (in_last_i || at_tail);
    in_ready_o  = busy && (fwd_win ? out_ready_i : 1'b1);
    beat_o      = in_valid_i && in_ready_o;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == WF_IDLE) |-> (!in_ready_o && !out_valid_o));

  p_hdr_sink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid_i && pos_i < hdr_q_i) |-> (in_ready_o && !out_valid_o));

  p_tail_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == WF_PASS && in_valid_i && pos_i >= end_q_i) |-> (in_ready_o && !out_valid_o));

  p_drain_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == WF_DRAIN) |-> !out_valid_o);
endmodule

// File: rtl/img_window_filter.sv
module img_window_filter
  import wf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       hdr_len_i,
  input  logic [31:0]       pay_len_i,
  input  logic [31:0]       img_len_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic      fit_w, beat_w;
  wf_len_t   end_w, pos_w, hdr_q_w, end_q_w;
  wf_state_e state_w;

  wf_len_check u_chk (
    .hdr_i (hdr_len_i),
    .pay_i (pay_len_i),
    .img_i (img_len_i),
    .fit_o (fit_w),
    .end_o (end_w)
  );

  wf_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .fit_i   (fit_w),
    .hdr_i   (hdr_len_i),
    .end_i   (end_w),
    .beat_i  (beat_w),
    .last_i  (in_last_i),
    .state_o (state_w),
    .pos_o   (pos_w),
    .hdr_q_o (hdr_q_w),
    .end_q_o (end_q_w),
    .busy_o  (busy_o),
    .err_o   (err_o),
    .done_o  (done_o)
  );

  wf_steer #(.DATA_W(DATA_W)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state_w),
    .pos_i       (pos_w),
    .hdr_q_i     (hdr_q_w),
    .end_q_i     (end_q_w),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_last_i   (in_last_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i),
    .beat_o      (beat_w)
  );

  p_err_no_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !out_valid_o);

  p_last_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o);
endmodule

// File: tb/sim_img_window_filter.sv
`timescale 1ns/1ps
module sim_img_window_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] hdr_len_i = '0, pay_len_i = '0, img_len_i = '0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o, out_valid_o, out_last_o, busy_o, done_o, err_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  img_window_filter u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .hdr_len_i(hdr_len_i), .pay_len_i(pay_len_i), .img_len_i(img_len_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [31:0] hdr;
    logic [31:0] pay;
    logic [31:0] img;
    logic [31:0] n;
    logic        stall;
    logic        inj;
    logic        err;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [0:NVEC-1] = '{
    '{32'd3,  32'd4,  32'd10, 32'd10, 1'b0, 1'b0, 1'b0},
    '{32'd0,  32'd2,  32'd5,  32'd5,  1'b1, 1'b0, 1'b0},
    '{32'd2,  32'd0,  32'd6,  32'd6,  1'b0, 1'b0, 1'b0},
    '{32'd4,  32'd3,  32'd7,  32'd7,  1'b1, 1'b1, 1'b0},
    '{32'd5,  32'd4,  32'd8,  32'd8,  1'b0, 1'b0, 1'b1},
    '{32'hFFFF_FFF0, 32'h20, 32'h40, 32'd6, 1'b0, 1'b0, 1'b1},
    '{32'd1,  32'd0,  32'd20, 32'd5,  1'b0, 1'b0, 1'b0},
    '{32'd6,  32'd0,  32'd6,  32'd6,  1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_case(input vec_t v);
    longint wend, fwd_end, sent;
    bit     exp_err;
    int     fwd_cnt;
    string  tag;
    exp_err = (longint'(v.hdr) + longint'(v.pay)) > longint'(v.img);
    chk(exp_err == v.err, "R11 table", exp_err, v.err);
    wend    = (v.pay == 0) ? longint'(v.img) : longint'(v.hdr) + longint'(v.pay);
    fwd_end = (wend < longint'(v.n)) ? wend : longint'(v.n);
    fwd_cnt = 0;
    sent    = 0;
    @(negedge clk);
    start_i = 1'b1; hdr_len_i = v.hdr; pay_len_i = v.pay; img_len_i = v.img;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    chk(err_o == exp_err, "R8 err after start", err_o, exp_err);
    for (longint k = 0; k < longint'(v.n); k++) begin
      bit exp_fwd;
      @(negedge clk);
      start_i = 1'b0;
      in_valid_i = 1'b1;
      in_data_i  = 8'(k) ^ 8'h5A;
      in_last_i  = (k == longint'(v.n) - 1);
      if (v.inj && k == 2) begin
        start_i = 1'b1; hdr_len_i = 32'd0; pay_len_i = 32'd1; img_len_i = 32'd2;
      end
      exp_fwd = !exp_err && (k >= longint'(v.hdr)) && (k < wend);
      if (exp_err)                   tag = "R8/R11 drained";
      else if (k < longint'(v.hdr))  tag = "R2 header";
      else if (k >= wend)            tag = "R6 tail";
      else if (v.hdr == 0 && k == 0) tag = "R3 first";
      else if (v.inj)                tag = "R10 busy start";
      else if (v.pay == 0)           tag = "R5 to end";
      else                           tag = "R4 payload";
      if (v.stall && exp_fwd) begin
        out_ready_i = 1'b0;
        #1;
        chk(out_valid_o == 1'b1 && in_ready_o == 1'b0, "R4 stall", in_ready_o, 0);
        @(negedge clk);
        out_ready_i = 1'b1;
      end
      #1;
      chk(in_ready_o == 1'b1, tag, in_ready_o, 1);
      chk(out_valid_o == exp_fwd, tag, out_valid_o, exp_fwd);
      if (exp_fwd) begin
        fwd_cnt++;
        chk(out_data_o == in_data_i, tag, out_data_o, in_data_i);
        chk(out_last_o == (k == fwd_end - 1), "R7 last", out_last_o, (k == fwd_end - 1));
      end
      sent++;
    end
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0; start_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R9 done pulse", done_o, 1);
    chk(busy_o == 1'b0, "R9 idle after last", busy_o, 0);
    chk(err_o == exp_err, "R8 err held", err_o, exp_err);
    begin
      longint exp_cnt;
      exp_cnt = exp_err ? 0 : ((fwd_end > longint'(v.hdr)) ? fwd_end - longint'(v.hdr) : 0);
      chk(fwd_cnt == exp_cnt, v.inj ? "R10 count" : "R6 count", fwd_cnt, exp_cnt);
    end
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, "R9 done single", done_o, 0);
    chk(in_ready_o == 1'b0, "R1 idle not ready", in_ready_o, 0);
  endtask

  initial begin
    #1;
    chk(in_ready_o == 0 && out_valid_o == 0 && busy_o == 0, "R1 in reset", busy_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b1;
    #1;
    chk(in_ready_o == 1'b0, "R1 idle ignores input", in_ready_o, 0);
    chk(done_o == 0 && err_o == 0 && out_last_o == 0, "R1 reset flags", err_o, 0);
    in_valid_i = 1'b0;
    for (int i = 0; i < NVEC; i++) run_case(VEC[i]);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule